// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Slot Matcher

This block decides, once per access, whether one of a set of hardware debug comparator slots fires. There are two banks of slots. Breakpoint slots hold a control word and a 64-bit value word, and compare the value word against the program counter of an instruction fetch. Watchpoint slots hold only a control word. Their address comparison is done elsewhere and arrives as one hit bit per slot.

A raw hit is then qualified by several fields of the slot's control word. A security-state field says whether the slot may fire in secure state, non-secure state or both. A privilege field and a hypervisor-level bit decide at which exception levels it may fire. A link bit can chain the slot to a context-aware breakpoint slot. That slot then has to match the current 32-bit context identifier.

A global debug gate can suppress everything. Among the slots that survive, the lowest index wins. The result is registered, so it appears one cycle after the access strobe. Raising the exception and building its syndrome are left to the consumer of the fire output.

Top module: `dbg_slot_matcher`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fire` is 0 and `fire_idx` is 0.
- R2: A fetch access (`acc_is_data`=0) with `acc_valid`=1 fires breakpoint slot n in the next cycle only if control bit 0 of slot n is 1 and bits [PC_W-1:0] of its value word equal `acc_pc`. Upper value bits are ignored. In the cycle after `acc_valid`=0, `fire` is 0.
- R3: A data access (`acc_is_data`=1) fires watchpoint slot n only if `wp_hit[n]`=1 and control bit 0 of that slot is 1.
- R4: Security field, control bits [15:14]. A value of 1 or 3 blocks the slot when `secure`=1. A value of 2 blocks it when `secure`=0. A value of 0 blocks nothing.
- R5: Level qualification. At level 2 or 3 the slot needs control bit 13. At level 1 it needs control bit 1. At level 0 it needs control bit 2.
- R6: For a data access with `acc_unpriv`=1, watchpoint slots are level-qualified as level 0, whatever `cur_el` is. Fetch accesses ignore `acc_unpriv`.
- R7: When control bit 20 of a slot is 1, the slot fires only if the breakpoint slot numbered by its bits [19:16] passes the context check of R8. A number at or above NUM_BP, or below NUM_BP-NUM_CTX, never passes.
- R8: A linked breakpoint slot passes only if all of these hold: its control bit 0 is 1; its bits [23:20] equal 3; `cur_el` (the real level, even for unprivileged accesses) is 0 or 1; and `ctx_id` equals bits [31:0] of its value word.
- R9: Nothing fires unless both `mon_dbg_en` and `dbg_exc_ok` are 1.
- R10: When several slots qualify, `fire_idx` is the lowest qualifying index within the accessed bank. `fire_idx` is 0 whenever `fire` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_is_data | input | 1 | 1 = data access (watchpoint bank), 0 = fetch (breakpoint bank) |
| acc_pc | input | PC_W | Program counter of the fetch |
| acc_unpriv | input | 1 | Data access made with unprivileged semantics |
| wp_hit | input | NUM_WP | Per-watchpoint address hit |
| cur_el | input | 2 | Current exception level |
| secure | input | 1 | Current security state is secure |
| ctx_id | input | 32 | Current context identifier |
| mon_dbg_en | input | 1 | Global monitor-debug enable |
| dbg_exc_ok | input | 1 | Debug exceptions may be taken now |
| bp_ctrl | input | 32*NUM_BP | Breakpoint control words, slot n at [32n+31:32n] |
| bp_value | input | 64*NUM_BP | Breakpoint value words, slot n at [64n+63:64n] |
| wp_ctrl | input | 32*NUM_WP | Watchpoint control words, slot n at [32n+31:32n] |
| fire | output | 1 | A slot fired for the previous access |
| fire_idx | output | IDX_W | Index of the firing slot |

## Verification
The bench builds the block with four breakpoint slots, the top two of them context-aware, two watchpoint slots and an 8-bit program counter. At that size the bench can sweep several spaces completely. It sweeps every combination of level, security state, security field, privilege bits and hypervisor bit. It sweeps every program counter value, and all sixteen link numbers, which covers both the below-range and above-range link targets. It also sweeps every enable mask for the priority check. Expected results come from a model in the bench written from the field rules.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;

   localparam int CTRL_W  = 32;
   localparam int VAL_W   = 64;
   localparam int CTX_W   = 32;
   localparam int LBN_W   = 4;
   localparam int LBN_SPAN = 1 << LBN_W;
   localparam logic [3:0] KIND_CTX_MATCH = 4'd3;

   typedef enum logic [1:0] {
      LVL0 = 2'd0,
      LVL1 = 2'd1,
      LVL2 = 2'd2,
      LVL3 = 2'd3
   } dbg_lvl_e;

   typedef struct packed {
      logic             en;
      logic [1:0]       priv_ctl;
      logic             hyp_ok;
      logic [1:0]       sec_ctl;
      logic [LBN_W-1:0] link_no;
      logic [3:0]       kind;
   } slot_ctrl_t;

   function automatic slot_ctrl_t decode_ctrl(input logic [CTRL_W-1:0] w);
      slot_ctrl_t c;
      c.en       = w[0];
      c.priv_ctl = w[2:1];
      c.hyp_ok   = w[13];
      c.sec_ctl  = w[15:14];
      c.link_no  = w[19:16];
      c.kind     = w[23:20];
      return c;
   endfunction

endpackage

// File: rtl/dbg_ctx_check.sv
module dbg_ctx_check
   import dbg_match_pkg::*;
#(
   parameter bit CTX_AWARE = 1'b1
) (
   input  logic             en,
   input  logic [3:0]       kind,
   input  logic [CTX_W-1:0] cmp_val,
   input  logic [1:0]       cur_el,
   input  logic [CTX_W-1:0] ctx_id,
   output logic             pass
);

   generate
      if (CTX_AWARE) begin : g_aware
         logic low_level;
         assign low_level = (cur_el == LVL0) || (cur_el == LVL1);
         assign pass = en && (kind == KIND_CTX_MATCH) && low_level && (ctx_id == cmp_val);
      end else begin : g_plain
         logic unused_in;
         assign unused_in = ^{en, kind, cmp_val, cur_el, ctx_id};
         assign pass = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/dbg_slot_qual.sv
module dbg_slot_qual
   import dbg_match_pkg::*;
(
   input  slot_ctrl_t ctrl,
   input  logic       addr_hit,
   input  logic       secure,
   input  logic [1:0] lvl,
   input  logic       link_pass,
   output logic       match
);

   logic sec_ok;
   logic lvl_ok;
   logic link_ok;

   always_comb begin
      unique case (ctrl.sec_ctl)
         2'd0:    sec_ok = 1'b1;
         2'd2:    sec_ok = secure;
         default: sec_ok = !secure;
      endcase
   end

   always_comb begin
      unique case (dbg_lvl_e'(lvl))
         LVL0:    lvl_ok = ctrl.priv_ctl[1];
         LVL1:    lvl_ok = ctrl.priv_ctl[0];
         default: lvl_ok = ctrl.hyp_ok;
      endcase
   end

   assign link_ok = !ctrl.kind[0] || link_pass;
   assign match   = ctrl.en && addr_hit && sec_ok && lvl_ok && link_ok;

endmodule

// File: rtl/dbg_prio_pick.sv
module dbg_prio_pick #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      any = |req;
      idx = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (req[k]) idx = IDX_W'(k);
      end
   end

endmodule

// File: rtl/dbg_slot_matcher.sv
module dbg_slot_matcher
   import dbg_match_pkg::*;
#(
   parameter int NUM_BP  = 6,
   parameter int NUM_CTX = 2,
   parameter int NUM_WP  = 4,
   parameter int PC_W    = 48,
   localparam int MAXS      = (NUM_BP > NUM_WP) ? NUM_BP : NUM_WP,
   localparam int IDX_W     = (MAXS > 1) ? $clog2(MAXS) : 1,
   localparam int FIRST_CTX = NUM_BP - NUM_CTX
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     acc_valid,
   input  logic                     acc_is_data,
   input  logic [PC_W-1:0]          acc_pc,
   input  logic                     acc_unpriv,
   input  logic [NUM_WP-1:0]        wp_hit,
   input  logic [1:0]               cur_el,
   input  logic                     secure,
   input  logic [CTX_W-1:0]         ctx_id,
   input  logic                     mon_dbg_en,
   input  logic                     dbg_exc_ok,
   input  logic [CTRL_W*NUM_BP-1:0] bp_ctrl,
   input  logic [VAL_W*NUM_BP-1:0]  bp_value,
   input  logic [CTRL_W*NUM_WP-1:0] wp_ctrl,
   output logic                     fire,
   output logic [IDX_W-1:0]         fire_idx
);

   generate
      if (NUM_BP < 1 || NUM_BP > LBN_SPAN) begin : g_bad_bp
         $error("NUM_BP must lie in 1..16");
      end
      if (NUM_CTX < 0 || NUM_CTX > NUM_BP) begin : g_bad_ctx
         $error("NUM_CTX must lie in 0..NUM_BP");
      end
      if (NUM_WP < 1) begin : g_bad_wp
         $error("NUM_WP must be at least 1");
      end
      if (PC_W < 1 || PC_W > VAL_W) begin : g_bad_pc
         $error("PC_W must lie in 1..64");
      end
   endgenerate

   logic unused_sink;
   assign unused_sink = ^{bp_ctrl, bp_value, wp_ctrl};

   logic                dbg_go;
   logic [1:0]          wp_lvl;
   logic [NUM_BP-1:0]   ctx_pass;
   logic [LBN_SPAN-1:0] ctx_ext;
   logic [NUM_BP-1:0]   bp_match;
   logic [NUM_WP-1:0]   wp_match;
   logic [MAXS-1:0]     bank_req;
   logic                pick_any;
   logic [IDX_W-1:0]    pick_idx;

   assign dbg_go = mon_dbg_en && dbg_exc_ok;
   assign wp_lvl = acc_unpriv ? 2'(LVL0) : cur_el;

   // Context check of every breakpoint slot, usable as a link target
   for (genvar j = 0; j < NUM_BP; j++) begin : g_ctx
      slot_ctrl_t cc;
      assign cc = decode_ctrl(bp_ctrl[j*CTRL_W +: CTRL_W]);
      dbg_ctx_check #(.CTX_AWARE(j >= FIRST_CTX)) u_ctx (
         .en      (cc.en),
         .kind    (cc.kind),
         .cmp_val (bp_value[j*VAL_W +: CTX_W]),
         .cur_el  (cur_el),
         .ctx_id  (ctx_id),
         .pass    (ctx_pass[j])
      );
   end

   // Link numbers past the implemented slots land on zero padding
   assign ctx_ext = LBN_SPAN'(ctx_pass);

   for (genvar j = 0; j < NUM_BP; j++) begin : g_bp
      slot_ctrl_t bc;
      logic       hit;
      assign bc  = decode_ctrl(bp_ctrl[j*CTRL_W +: CTRL_W]);
      assign hit = (bp_value[j*VAL_W +: PC_W] == acc_pc);
      dbg_slot_qual u_qual (
         .ctrl      (bc),
         .addr_hit  (hit),
         .secure    (secure),
         .lvl       (cur_el),
         .link_pass (ctx_ext[bc.link_no]),
         .match     (bp_match[j])
      );
   end

   for (genvar j = 0; j < NUM_WP; j++) begin : g_wp
      slot_ctrl_t wc;
      assign wc = decode_ctrl(wp_ctrl[j*CTRL_W +: CTRL_W]);
      dbg_slot_qual u_qual (
         .ctrl      (wc),
         .addr_hit  (wp_hit[j]),
         .secure    (secure),
         .lvl       (wp_lvl),
         .link_pass (ctx_ext[wc.link_no]),
         .match     (wp_match[j])
      );
   end

   assign bank_req = acc_is_data ? MAXS'(wp_match) : MAXS'(bp_match);

   dbg_prio_pick #(.N(MAXS), .IDX_W(IDX_W)) u_pick (
      .req (bank_req),
      .any (pick_any),
      .idx (pick_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fire     <= 1'b0;
         fire_idx <= '0;
      end else if (acc_valid && dbg_go && pick_any) begin
         fire     <= 1'b1;
         fire_idx <= pick_idx;
      end else begin
         fire     <= 1'b0;
         fire_idx <= '0;
      end
   end

   // R2: no strobe, no fire in the following cycle
   p_quiet_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !fire);

   // R3: a data access without any watchpoint hit cannot fire
   p_wp_needs_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_is_data && (wp_hit == '0)) |=> !fire);

   // R9: closed debug gate suppresses firing
   p_gate_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mon_dbg_en && dbg_exc_ok) |=> !fire);

   // R10: index is zero while idle
   p_idx_zero_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |-> (fire_idx == '0));

   // R10: the reported index lies inside the bank that was accessed
   p_idx_in_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> (32'(fire_idx) < ($past(acc_is_data) ? NUM_WP : NUM_BP)));

endmodule

// File: tb/dbg_slot_matcher_test.sv
`timescale 1ns/1ps
module dbg_slot_matcher_test;

   localparam int NBP = 4;
   localparam int NWP = 2;
   localparam int PCW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 1'b0;
   logic acc_is_data = 1'b0;
   logic [PCW-1:0] acc_pc = '0;
   logic acc_unpriv = 1'b0;
   logic [NWP-1:0] wp_hit = '0;
   logic [1:0] cur_el = 2'd1;
   logic secure = 1'b0;
   logic [31:0] ctx_id = 32'h1234_5678;
   logic mon_dbg_en = 1'b1;
   logic dbg_exc_ok = 1'b1;
   logic [31:0] bc [NBP];
   logic [63:0] bv [NBP];
   logic [31:0] wc [NWP];
   logic fire;
   logic [1:0] fire_idx;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dbg_slot_matcher #(.NUM_BP(NBP), .NUM_CTX(2), .NUM_WP(NWP), .PC_W(PCW)) uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_is_data(acc_is_data),
      .acc_pc(acc_pc), .acc_unpriv(acc_unpriv), .wp_hit(wp_hit), .cur_el(cur_el),
      .secure(secure), .ctx_id(ctx_id), .mon_dbg_en(mon_dbg_en), .dbg_exc_ok(dbg_exc_ok),
      .bp_ctrl({bc[3], bc[2], bc[1], bc[0]}),
      .bp_value({bv[3], bv[2], bv[1], bv[0]}),
      .wp_ctrl({wc[1], wc[0]}),
      .fire(fire), .fire_idx(fire_idx)
   );

   // control word built from field values
   function automatic logic [31:0] mk(bit en, int pac, bit hmc, int ssc, int lbn, int kind);
      return {8'h00, 4'(kind), 4'(lbn), 2'(ssc), hmc, 10'h000, 2'(pac), en};
   endfunction

   function automatic bit sec_ok(logic [31:0] c);
      if (c[15:14] == 2'd0) return 1'b1;
      if (c[15:14] == 2'd2) return secure;
      return !secure;
   endfunction

   function automatic bit lvl_ok(logic [31:0] c, int el);
      if (el >= 2) return c[13];
      if (el == 1) return c[1];
      return c[2];
   endfunction

   function automatic bit link_ok(int n);
      if (n >= NBP || n < 2) return 1'b0;
      return bc[n][0] && (bc[n][23:20] == 4'd3) && (cur_el <= 2'd1) && (ctx_id == bv[n][31:0]);
   endfunction

   function automatic bit slot_ok(logic [31:0] c, int el, bit hit);
      return c[0] && hit && sec_ok(c) && lvl_ok(c, el) && (!c[20] || link_ok(int'(c[19:16])));
   endfunction

   task automatic expect_out(output bit ef, output int ei);
      ef = 1'b0;
      ei = 0;
      if (!(mon_dbg_en && dbg_exc_ok)) return;
      if (acc_is_data) begin
         for (int i = NWP - 1; i >= 0; i--)
            if (wp_hit[i] && slot_ok(wc[i], acc_unpriv ? 0 : int'(cur_el), 1'b1)) begin
               ef = 1'b1; ei = i;
            end
      end else begin
         for (int i = NBP - 1; i >= 0; i--)
            if (slot_ok(bc[i], int'(cur_el), bv[i][PCW-1:0] == acc_pc)) begin
               ef = 1'b1; ei = i;
            end
      end
   endtask

   task automatic compare(string req, bit ef, int ei);
      checks++;
      if (fire !== ef || int'(fire_idx) != ei) begin
         errors++;
         $display("FAIL %s: fire=%0d idx=%0d expected fire=%0d idx=%0d", req, fire, fire_idx, ef, ei);
      end
   endtask

   task automatic run(string req);
      bit ef;
      int ei;
      expect_out(ef, ei);
      acc_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      compare(req, ef, ei);
   endtask

   task automatic idle(string req);
      acc_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      compare(req, 1'b0, 0);
   endtask

   task automatic clear_slots();
      for (int i = 0; i < NBP; i++) begin bc[i] = '0; bv[i] = '0; end
      for (int i = 0; i < NWP; i++) wc[i] = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      clear_slots();
      repeat (3) @(negedge clk);
      checks++;
      if (fire !== 1'b0 || fire_idx !== 2'd0) begin
         errors++;
         $display("FAIL R1 in reset: fire=%0d idx=%0d expected 0 0", fire, fire_idx);
      end
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after reset", 1'b0, 0);

      // R4 R5: qualification sweep on breakpoint slot 0
      bv[0] = 64'hDEAD_BEEF_CAFE_005A;
      acc_pc = 8'h5A;
      for (int el = 0; el < 4; el++)
         for (int s = 0; s < 2; s++)
            for (int ssc = 0; ssc < 4; ssc++)
               for (int pac = 0; pac < 4; pac++)
                  for (int h = 0; h < 2; h++) begin
                     cur_el = 2'(el);
                     secure = s[0];
                     bc[0] = mk(1'b1, pac, h[0], ssc, 0, 0);
                     run("R4 R5 qualification");
                  end

      // R2: program counter sweep, upper value bits ignored
      secure = 1'b0;
      cur_el = 2'd1;
      bc[0] = mk(1'b1, 3, 1'b1, 0, 0, 0);
      for (int p = 0; p < 256; p++) begin
         acc_pc = 8'(p);
         run("R2 pc compare");
      end
      acc_pc = 8'h5A;
      bc[0][0] = 1'b0;
      run("R2 disabled slot");
      bc[0][0] = 1'b1;
      run("R2 enabled slot");
      idle("R2 no strobe");

      // R3: watchpoint hit and enable sweep, also R10 priority
      clear_slots();
      acc_is_data = 1'b1;
      for (int h = 0; h < 4; h++)
         for (int e = 0; e < 4; e++) begin
            wp_hit = 2'(h);
            wc[0] = mk(e[0], 3, 1'b1, 0, 0, 0);
            wc[1] = mk(e[1], 3, 1'b1, 0, 0, 0);
            run("R3 R10 watchpoint hit");
         end

      // R6: unprivileged data access qualifies as level 0
      wc[0] = mk(1'b1, 2, 1'b0, 0, 0, 0);
      wc[1] = '0;
      wp_hit = 2'b01;
      for (int el = 0; el < 4; el++)
         for (int u = 0; u < 2; u++) begin
            cur_el = 2'(el);
            acc_unpriv = u[0];
            run("R6 unprivileged watchpoint");
         end
      acc_is_data = 1'b0;
      acc_unpriv = 1'b1;
      cur_el = 2'd1;
      bc[0] = mk(1'b1, 2, 1'b0, 0, 0, 0);
      bv[0] = 64'h5A;
      run("R6 fetch ignores unprivileged flag");
      acc_unpriv = 1'b0;

      // R7 R8: link number, level and context sweep
      bc[0] = mk(1'b1, 3, 1'b1, 0, 0, 1);
      bc[1] = mk(1'b1, 0, 1'b0, 0, 0, 3);  bv[1] = 64'h1234_5678;
      bc[2] = mk(1'b1, 0, 1'b0, 0, 0, 3);  bv[2] = 64'hFFFF_0000_1234_5678;
      bc[3] = mk(1'b1, 0, 1'b0, 0, 0, 3);  bv[3] = 64'h8765_4321;
      for (int l = 0; l < 16; l++)
         for (int el = 0; el < 4; el++)
            for (int m = 0; m < 2; m++) begin
               bc[0][19:16] = 4'(l);
               cur_el = 2'(el);
               ctx_id = m[0] ? 32'h1234_5678 : 32'h8765_4321;
               run("R7 R8 linked context");
            end
      cur_el = 2'd1;
      ctx_id = 32'h1234_5678;
      bc[0][19:16] = 4'd2;
      for (int k = 0; k < 16; k++) begin
         bc[2][23:20] = 4'(k);
         run("R8 linked slot kind");
      end
      bc[2][23:20] = 4'd3;
      bc[2][0] = 1'b0;
      run("R8 linked slot disabled");
      bc[2][0] = 1'b1;

      // R8: unprivileged data access still uses the real level for the link
      acc_is_data = 1'b1;
      acc_unpriv = 1'b1;
      wc[0] = mk(1'b1, 2, 1'b0, 0, 2, 1);
      wp_hit = 2'b01;
      for (int el = 0; el < 4; el++) begin
         cur_el = 2'(el);
         run("R6 R8 unprivileged linked watchpoint");
      end
      acc_unpriv = 1'b0;
      acc_is_data = 1'b0;

      // R9: global gate
      clear_slots();
      cur_el = 2'd1;
      bc[1] = mk(1'b1, 3, 1'b1, 0, 0, 0);
      bv[1] = 64'h5A;
      for (int g = 0; g < 4; g++) begin
         mon_dbg_en = g[0];
         dbg_exc_ok = g[1];
         run("R9 debug gate");
      end

      // R10: lowest index wins across every enable mask
      for (int i = 0; i < NBP; i++) begin
         bc[i] = mk(1'b0, 3, 1'b1, 0, 0, 0);
         bv[i] = 64'h5A;
      end
      for (int msk = 0; msk < 16; msk++) begin
         for (int i = 0; i < NBP; i++) bc[i][0] = msk[i];
         run("R10 priority");
      end
      idle("R10 idle index");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule